// File: doc/BRIEF.md
# Audio Automatic Level Controller

This block tames loud passages in a stream of signed audio samples. Each time a sample is flagged valid, its magnitude is compared against a programmable threshold. A loud sample deepens the attenuation by one 0.5 dB step. The controller then ignores the following samples for a programmable attack-hold time. Once a programmable number of consecutive samples has stayed at or below the threshold, the controller gives back one 0.5 dB step. It stops giving back gain at unity.

In limited recovery mode, a counter caps how many restoring steps may be taken. Disabling the block clears that counter. The current attenuation index is visible at all times. Every accepted sample is multiplied by a coefficient that is looked up from that index, and the result appears one cycle later, rounded and saturated. All decisions advance only on valid samples, so the block runs at any sample rate under a fast clock.

Top module: `alc_engine`

## Requirements
- R1: After reset, `attn_idx` is 0, `out_valid` is 0 and `out_sample` is 0.
- R2: When enabled, a valid sample whose magnitude is strictly greater than `thresh`, arriving outside a hold period, raises `attn_idx` by one at that clock edge, clamped at 2^ATTN_W-1 (63 by default).
- R3: After an attack step, the next `atk_time` valid samples are ignored and leave `attn_idx` unchanged, whatever their level.
- R4: Outside a hold period, a sample with magnitude at or below `thresh` counts as quiet. After `rec_time` consecutive quiet samples, `attn_idx` drops by one and the count restarts. A `rec_time` of 0 acts as 1.
- R5: A loud sample inside a recovery window discards the partial count. Counting restarts from zero after the new hold period.
- R6: With `attn_idx` at 0, quiet samples never change it.
- R7: With `rec_limited`=1, recovery stops after `rec_limit` restoring steps. The step count is cleared when `attn_idx` returns to 0 or the block is disabled. With `rec_limited`=0, recovery continues to 0.
- R8: While `enable` is 0, `attn_idx` is forced to 0 on every clock, the counters are cleared, and each valid sample is passed to `out_sample` unchanged.
- R9: `out_valid` follows `in_valid` one cycle later. `out_sample` = sat((s*C[k] + 2^14) >>> 15). Here k is the `attn_idx` value when the sample arrived, and C[k] = round(32768 * r^k) with r = 10^(-1/40), so C[0] = 32768.
- R10: The most negative sample, -2^(SAMPLE_W-1), has magnitude 2^(SAMPLE_W-1). It is therefore loud even when `thresh` is 2^(SAMPLE_W-1)-1.
- R11: Cycles without `in_valid` leave `attn_idx` unchanged while enabled, and `out_valid` is 0 after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Level control on; 0 forces unity gain and bypass |
| rec_limited | input | 1 | 0 = normal recovery, 1 = limited recovery |
| thresh | input | SAMPLE_W | Attack threshold on sample magnitude (unsigned) |
| atk_time | input | TIME_W | Samples ignored after each attack step |
| rec_time | input | TIME_W | Consecutive quiet samples per recovery step |
| rec_limit | input | ATTN_W | Maximum recovery steps in limited mode |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| attn_idx | output | ATTN_W | Current attenuation in 0.5 dB steps |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | SAMPLE_W | Signed gain-adjusted sample |

## Verification
The assertions check the following on every cycle:
- the attenuation index moves by at most one step per clock;
- the index holds still during a hold period, between strobes, and once the limited-recovery budget is spent;
- a disable drives the index to unity;
- the output strobe trails the input strobe by one cycle;
- a scaled sample is never larger in magnitude than its input.

Only the bench scenarios can show the exact sequence of steps:
- the attack/hold/recovery timing;
- the abort of a recovery window;
- the clamp at the deepest step;
- the special magnitude of the most negative sample;
- the bit-exact rounded output values.

// File: rtl/alc_pkg.sv
package alc_pkg;

   typedef enum logic {
      REC_NORMAL  = 1'b0,
      REC_LIMITED = 1'b1
   } rec_mode_e;

   // -0.5 dB expressed as a linear ratio, 10^(-1/40)
   localparam real STEP_RATIO = 0.944060876285923;

   // Coefficient for attenuation index k, unity scaled to 2^frac
   function automatic int unsigned coef_of(input int k, input int frac);
      real c;
      c = 1.0;
      for (int i = 0; i < frac; i++) c = c * 2.0;
      for (int i = 0; i < k; i++) c = c * STEP_RATIO;
      return int'($rtoi(c + 0.5));
   endfunction

endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect #(
   parameter int SAMPLE_W = 16
) (
   input  logic signed [SAMPLE_W-1:0] smp,
   input  logic        [SAMPLE_W-1:0] thresh,
   output logic        [SAMPLE_W-1:0] mag,
   output logic                       loud
);
   if (SAMPLE_W < 4) begin : g_bad_w
      $error("alc_level_detect: SAMPLE_W must be at least 4");
   end

   // Two's complement magnitude; the most negative value maps to 2^(W-1)
   always_comb begin
      if (smp[SAMPLE_W-1]) mag = ~smp + 1'b1;
      else                 mag = smp;
   end

   assign loud = mag > thresh;

endmodule

// File: rtl/alc_coef_rom.sv
module alc_coef_rom #(
   parameter int ATTN_W = 6,
   parameter int COEF_W = 16
) (
   input  logic [ATTN_W-1:0] idx,
   output logic [COEF_W-1:0] coef
);
   localparam int DEPTH = 1 << ATTN_W;
   localparam int FRAC  = COEF_W - 1;

   if (ATTN_W < 1 || ATTN_W > 9) begin : g_bad_a
      $error("alc_coef_rom: ATTN_W out of range 1..9");
   end
   if (COEF_W < 8 || COEF_W > 24) begin : g_bad_c
      $error("alc_coef_rom: COEF_W out of range 8..24");
   end

   logic [COEF_W-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      localparam int unsigned CVAL = alc_pkg::coef_of(k, FRAC);
      assign tbl[k] = CVAL[COEF_W-1:0];
   end

   assign coef = tbl[idx];

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl #(
   parameter int TIME_W = 12,
   parameter int ATTN_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              smp_valid,
   input  logic              loud,
   input  logic              rec_limited,
   input  logic [TIME_W-1:0] atk_time,
   input  logic [TIME_W-1:0] rec_time,
   input  logic [ATTN_W-1:0] rec_limit,
   output logic [ATTN_W-1:0] attn
);
   import alc_pkg::*;

   localparam logic [ATTN_W-1:0] ATTN_TOP = '1;
   localparam logic [TIME_W:0]   ONE_W    = {{TIME_W{1'b0}}, 1'b1};

   if (TIME_W < 2) begin : g_bad_t
      $error("alc_gain_ctrl: TIME_W must be at least 2");
   end

   logic [ATTN_W-1:0] attn_q, attn_n;
   logic [TIME_W-1:0] hold_q, hold_n;
   logic [TIME_W-1:0] rec_q, rec_n;
   logic [ATTN_W-1:0] step_q, step_n;
   rec_mode_e         mode;
   logic [TIME_W:0]   rec_target;
   logic              rec_blocked;
   logic              rec_done;
   logic              holding;

   assign mode        = rec_mode_e'(rec_limited);
   assign holding     = hold_q != '0;
   assign rec_target  = (rec_time == '0) ? ONE_W : {1'b0, rec_time};
   assign rec_done    = ({1'b0, rec_q} + ONE_W) >= rec_target;
   assign rec_blocked = (attn_q == '0) ||
                        ((mode == REC_LIMITED) && (step_q >= rec_limit));

   always_comb begin
      attn_n = attn_q;
      hold_n = hold_q;
      rec_n  = rec_q;
      step_n = step_q;
      if (!enable) begin
         attn_n = '0;
         hold_n = '0;
         rec_n  = '0;
         step_n = '0;
      end else if (smp_valid) begin
         if (holding) begin
            hold_n = hold_q - 1'b1;
         end else if (loud) begin
            if (attn_q != ATTN_TOP) attn_n = attn_q + 1'b1;
            hold_n = atk_time;
            rec_n  = '0;
         end else if (rec_blocked) begin
            rec_n = '0;
         end else if (rec_done) begin
            attn_n = attn_q - 1'b1;
            rec_n  = '0;
            if (step_q != ATTN_TOP) step_n = step_q + 1'b1;
         end else begin
            rec_n = rec_q + 1'b1;
         end
         if (attn_n == '0) step_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attn_q <= '0;
         hold_q <= '0;
         rec_q  <= '0;
         step_q <= '0;
      end else begin
         attn_q <= attn_n;
         hold_q <= hold_n;
         rec_q  <= rec_n;
         step_q <= step_n;
      end
   end

   assign attn = attn_q;

   // R2: one step at most per clock
   p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (attn_q == $past(attn_q)) ||
                 (32'(attn_q) == 32'($past(attn_q)) + 1) ||
                 (32'(attn_q) + 1 == 32'($past(attn_q))));

   // R3: the index is frozen while the hold counter runs
   p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && holding) |=> $stable(attn_q));

   // R11: no strobe, no change
   p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !smp_valid) |=> $stable(attn_q));

   // R8: disable forces unity
   p_off_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> attn_q == '0);

   // R7: spent budget in limited mode blocks recovery
   p_limit_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == REC_LIMITED && step_q >= rec_limit && !loud)
      |=> attn_q == $past(attn_q));

endmodule

// File: rtl/alc_gain_apply.sv
module alc_gain_apply #(
   parameter int SAMPLE_W      = 16,
   parameter int COEF_W        = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   input  logic        [COEF_W-1:0]   coef,
   input  logic                       bypass,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_sample
);
   localparam int FRAC = COEF_W - 1;
   localparam int PW   = SAMPLE_W + COEF_W + 1;
   localparam logic signed [PW-1:0] SMAX =
      {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [PW-1:0] SMIN =
      {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

   logic signed [PW-1:0]       prod;
   logic signed [PW-1:0]       biased;
   logic signed [PW-1:0]       scaled;
   logic signed [SAMPLE_W-1:0] sat;

   assign prod = PW'(in_sample) * PW'($signed({1'b0, coef}));

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PW-1:0] HALF =
         {{(PW-1){1'b0}}, 1'b1} << (FRAC - 1);
      assign biased = prod + HALF;
   end else begin : g_trunc
      assign biased = prod;
   end

   assign scaled = biased >>> FRAC;

   always_comb begin
      if (scaled > SMAX)      sat = SMAX[SAMPLE_W-1:0];
      else if (scaled < SMIN) sat = SMIN[SAMPLE_W-1:0];
      else                    sat = scaled[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= bypass ? in_sample : sat;
      end
   end

   function automatic logic [SAMPLE_W:0] absv(input logic signed [SAMPLE_W-1:0] v);
      return v[SAMPLE_W-1] ? (SAMPLE_W+1)'(-(SAMPLE_W+1)'(v)) : (SAMPLE_W+1)'(v);
   endfunction

   // R9: strobe latency of one cycle
   p_strobe_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9: attenuation never amplifies
   p_no_growth_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> absv(out_sample) <= absv($past(in_sample)));

endmodule

// File: rtl/alc_engine.sv
module alc_engine #(
   parameter int SAMPLE_W      = 16,
   parameter int TIME_W        = 12,
   parameter int ATTN_W        = 6,
   parameter int COEF_W        = 16,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable,
   input  logic                       rec_limited,
   input  logic        [SAMPLE_W-1:0] thresh,
   input  logic        [TIME_W-1:0]   atk_time,
   input  logic        [TIME_W-1:0]   rec_time,
   input  logic        [ATTN_W-1:0]   rec_limit,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   output logic        [ATTN_W-1:0]   attn_idx,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_sample
);
   logic [SAMPLE_W-1:0] mag;
   logic                loud;
   logic [COEF_W-1:0]   coef;

   alc_level_detect #(.SAMPLE_W(SAMPLE_W)) u_det (
      .smp    (in_sample),
      .thresh (thresh),
      .mag    (mag),
      .loud   (loud)
   );

   alc_gain_ctrl #(.TIME_W(TIME_W), .ATTN_W(ATTN_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .smp_valid   (in_valid),
      .loud        (loud),
      .rec_limited (rec_limited),
      .atk_time    (atk_time),
      .rec_time    (rec_time),
      .rec_limit   (rec_limit),
      .attn        (attn_idx)
   );

   alc_coef_rom #(.ATTN_W(ATTN_W), .COEF_W(COEF_W)) u_rom (
      .idx  (attn_idx),
      .coef (coef)
   );

   alc_gain_apply #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_apply (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .coef       (coef),
      .bypass     (!enable),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   // R10: the most negative code is always loud unless thresh covers 2^(W-1)
   p_negmax_loud_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sample == {1'b1, {(SAMPLE_W-1){1'b0}}} &&
       thresh == {1'b0, {(SAMPLE_W-1){1'b1}}}) |-> (loud && mag[SAMPLE_W-1]));

   // R8: bypass passes the sample through unchanged
   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && in_valid) |=> out_sample == $past(in_sample));

endmodule

// File: tb/alc_engine_bench.sv
module alc_engine_bench;
   localparam int SW = 16;
   localparam int TW = 12;
   localparam int AW = 6;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 enable = 1'b0;
   logic                 rec_limited = 1'b0;
   logic        [SW-1:0] thresh = '0;
   logic        [TW-1:0] atk_time = '0;
   logic        [TW-1:0] rec_time = '0;
   logic        [AW-1:0] rec_limit = '0;
   logic                 in_valid = 1'b0;
   logic signed [SW-1:0] in_sample = '0;
   logic        [AW-1:0] attn_idx;
   logic                 out_valid;
   logic signed [SW-1:0] out_sample;

   int tests = 0;
   int fails = 0;
   int prev_attn = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   alc_engine u_alc_engine (
      .clk(clk), .rst_n(rst_n), .enable(enable), .rec_limited(rec_limited),
      .thresh(thresh), .atk_time(atk_time), .rec_time(rec_time),
      .rec_limit(rec_limit), .in_valid(in_valid), .in_sample(in_sample),
      .attn_idx(attn_idx), .out_valid(out_valid), .out_sample(out_sample)
   );

   // Table walk: thresh 1000, hold 2, recovery window 3, normal mode
   localparam int NV = 23;
   localparam int VS [NV] = '{2000, 2000, 2000, 2000, 0, 0, 0, 0, -1001, 0, 0,
                              500, 1000, -1000, 0, 0, 0, 0, 0, 0, 0, 0, 0};
   localparam int VA [NV] = '{1, 1, 1, 2, 2, 2, 2, 2, 3, 3, 3,
                              3, 3, 2, 2, 2, 1, 1, 1, 0, 0, 0, 0};

   function automatic longint coef_m(input int k);
      real c;
      c = 32768.0;
      for (int i = 0; i < k; i++) c = c * 0.944060876285923;
      return longint'($rtoi(c + 0.5));
   endfunction

   function automatic longint scale_m(input longint s, input int k);
      longint p;
      p = (s * coef_m(k) + 16384) >>> 15;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return p;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one strobe and sample results at the following falling edge
   task automatic send(input int s);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = SW'(s);
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic send_chk(input string req, input int s, input int exp_attn);
      longint exp_out;
      exp_out = enable ? scale_m(s, prev_attn) : longint'(s);
      send(s);
      check(req, attn_idx, exp_attn);
      check(req, out_sample, exp_out);
      check(req, out_valid, 1);
      prev_attn = exp_attn;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", attn_idx, 0);
      check("R1", out_valid, 0);
      check("R1", out_sample, 0);
      rst_n = 1'b1;

      enable = 1'b1; thresh = 16'd1000; atk_time = 12'd2; rec_time = 12'd3;
      // R2 R3 R4 R5 R6 R9: table of attack, hold, abort and recovery
      for (int i = 0; i < NV; i++) send_chk("R2/R3/R4/R5/R6/R9 table", VS[i], VA[i]);

      // R2: clamp at the deepest step with no hold
      atk_time = 12'd0;
      for (int i = 0; i < 70; i++) send_chk("R2 clamp", 20000, (i + 1 > 63) ? 63 : i + 1);

      // R11: idle cycles
      repeat (5) @(negedge clk);
      check("R11 idle attn", attn_idx, 63);
      check("R11 idle strobe", out_valid, 0);

      // R8: disable forces unity and bypasses
      enable = 1'b0;
      @(negedge clk);
      check("R8 forced unity", attn_idx, 0);
      prev_attn = 0;
      send_chk("R8 bypass", -12345, 0);
      send_chk("R8 loud ignored", 30000, 0);

      // R10: most negative code is loud at the widest threshold
      enable = 1'b1; thresh = 16'h7FFF;
      send_chk("R10 equal is quiet", 32767, 0);
      send_chk("R10 negmax loud", -32768, 1);

      // R7: limited recovery, budget of 2 steps
      enable = 1'b0;
      @(negedge clk);
      prev_attn = 0;
      enable = 1'b1; thresh = 16'd1000; rec_time = 12'd1;
      rec_limited = 1'b1; rec_limit = 6'd2;
      for (int i = 0; i < 5; i++) send_chk("R7 build", 5000, i + 1);
      for (int i = 0; i < 6; i++) send_chk("R7 limited", 0, (i < 2) ? 4 - i : 3);

      // R7 R4: normal mode resumes, rec_time 0 acts as 1
      rec_limited = 1'b0; rec_time = 12'd0;
      for (int i = 0; i < 3; i++) send_chk("R7/R4 normal", 0, 2 - i);
      send_chk("R6 stays unity", 0, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule